// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a synchronous SRAM with a registered read path and a four-beat internal burst counter. A word is made of several byte lanes of equal width. The default is four lanes of nine bits, which gives eight data bits and one parity bit per lane and a 36-bit word. The address, the strobes, the chip selects and the write controls are all sampled on the rising clock edge.

An access starts on one of two strobes. The processor strobe always opens with a read-type cycle, and any write it carries lands on the following edge. The controller strobe finishes a write in the same cycle. After a start, edges with no strobe either advance the burst or hold it in place. The burst order is fixed at build time: linear or interleaved.

Read data is returned on a separate output bus together with a valid flag. The output enable acts on the flag without waiting for a clock edge. A sleep input freezes the block while keeping the stored contents.

Top module: `pbsram_core`

## Requirements
- R1: After reset, `rdata_vld_o` is low and `rdata_o` is zero until a read has passed through the pipeline.
- R2: A controller-strobe cycle (`ctl_stb_n` low, with no honoured processor strobe) with all three selects active (`sel0_n`=0, `sel1`=1, `sel2_n`=0) writes `wdata_i` at `addr_i` on that same edge when the write controls request a write.
- R3: A read accepted on edge E appears on `rdata_o` with `rdata_vld_o` high after edge E+1, and not after edge E. Back-to-back reads return one word per cycle.
- R4: Lane i is bits [9i+8:9i]. `wr_all_n`=0 writes every lane, whatever the lane selects. Otherwise, `wr_lane_en_n`=0 writes each lane i whose `lane_sel_n[i]` is 0. If no lane is chosen, the cycle is a read.
- R5: On an edge that honours the processor strobe, the write controls are ignored. A write supplied on the next edge, with both strobes high and `adv_n` high, stores at the strobed address.
- R6: The processor strobe is ignored while `sel0_n` is high. If a burst is open, that edge acts as an ordinary continue or suspend cycle.
- R7: When both strobes are low on the same edge with `sel0_n` low, only the processor strobe is honoured. The write controls on that edge have no effect.
- R8: An honoured strobe with any select inactive closes the burst. The output is invalid from one edge later, and edges with no strobe after it perform no access.
- R9: With both strobes high and `adv_n` low, the burst moves to the next beat. In linear order, the two low address bits step +1 modulo 4 from the strobed value.
- R10: With both strobes high and `adv_n` high, the burst repeats the access at the current address.
- R11: In interleaved order (`INTERLEAVE`=1), beat n accesses the low bits base XOR n.
- R12: `drive_n` high forces `rdata_vld_o` low and `rdata_o` to zero at once, without a clock edge. Lowering it restores the held data.
- R13: On the cycle after a write edge, `rdata_vld_o` is low even if a read result is held in the output register.
- R14: The block is asleep from the second edge after `sleep_i` rises until the second edge after it falls. While asleep, no access is made and the output is invalid. An open burst is dropped, and the stored contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr_i | input | AW | Word address, sampled on strobe edges |
| proc_stb_n | input | 1 | Processor start strobe, active low |
| ctl_stb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel0_n | input | 1 | Chip select, active low; also gates the processor strobe |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_lane_en_n | input | 1 | Lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| drive_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not valid |
| rdata_vld_o | output | 1 | Read data valid |

## Verification
The bench builds two copies that share one stimulus. The first is linear with 64 words, so every address used can be preloaded and tracked in a bench-side array. The second is interleaved with 16 words, so a single burst from an odd base separates the two beat orders. The small depths keep the full preload short and leave the cycle budget for burst, sleep and strobe-conflict sequences.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;

   localparam int unsigned BEAT_W = 2;

   typedef logic [BEAT_W-1:0] beat_t;

   // Linear burst: beat offset added to the strobed low bits
   function automatic beat_t beat_lin(input beat_t base, input beat_t n);
      return base + n;
   endfunction

   // Interleaved burst: beat offset XORed into the strobed low bits
   function automatic beat_t beat_xor(input beat_t base, input beat_t n);
      return base ^ n;
   endfunction

endpackage

// File: rtl/pbsram_burst_seq.sv
module pbsram_burst_seq
   import pbsram_pkg::*;
#(
   parameter bit INTERLEAVE = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  load_i,
   input  beat_t base_i,
   input  logic  step_i,
   output beat_t beat_o
);

   beat_t base_q;
   beat_t cnt_q;
   beat_t cnt_use;

   assign cnt_use = step_i ? beat_t'(cnt_q + 2'd1) : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
      end else if (load_i) begin
         base_q <= base_i;
         cnt_q  <= '0;
      end else if (step_i) begin
         cnt_q  <= cnt_use;
      end
   end

   generate
      if (INTERLEAVE) begin : g_xor
         assign beat_o = beat_xor(base_q, cnt_use);
      end else begin : g_lin
         assign beat_o = beat_lin(base_q, cnt_use);
      end
   endgenerate

endmodule

// File: rtl/pbsram_ctrl.sv
module pbsram_ctrl
   import pbsram_pkg::*;
#(
   parameter int AW         = 9,
   parameter int LANES      = 4,
   parameter bit INTERLEAVE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             asleep_i,
   input  logic [AW-1:0]    addr_i,
   input  logic             proc_stb_n,
   input  logic             ctl_stb_n,
   input  logic             adv_n,
   input  logic             sel0_n,
   input  logic             sel1,
   input  logic             sel2_n,
   input  logic             wr_all_n,
   input  logic             wr_lane_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   output logic             acc_valid_o,
   output logic             acc_wr_o,
   output logic [AW-1:0]    acc_addr_o,
   output logic [LANES-1:0] acc_mask_o
);

   localparam int HI_W = AW - BEAT_W;

   logic             p_hit;
   logic             strobe;
   logic             chip_on;
   logic             start;
   logic             desel;
   logic             cont;
   logic             active_q;
   logic [HI_W-1:0]  hi_q;
   logic [LANES-1:0] mask_req;
   beat_t            beat;

   // processor strobe only counts with the first select active
   assign p_hit   = !proc_stb_n && !sel0_n;
   assign strobe  = p_hit || !ctl_stb_n;
   assign chip_on = !sel0_n && sel1 && !sel2_n;

   assign start = !asleep_i && strobe && chip_on;
   assign desel = !asleep_i && strobe && !chip_on;
   assign cont  = !asleep_i && !strobe && active_q;

   always_comb begin
      if (!wr_all_n)          mask_req = '1;
      else if (!wr_lane_en_n) mask_req = ~lane_sel_n;
      else                    mask_req = '0;
   end

   // a processor-started edge never writes
   assign acc_mask_o  = (cont || (start && !p_hit)) ? mask_req : '0;
   assign acc_valid_o = start || cont;
   assign acc_wr_o    = acc_valid_o && (|acc_mask_o);
   assign acc_addr_o  = start ? addr_i : {hi_q, beat};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         hi_q     <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         hi_q     <= addr_i[AW-1:BEAT_W];
      end else if (desel || asleep_i) begin
         active_q <= 1'b0;
      end
   end

   pbsram_burst_seq #(
      .INTERLEAVE (INTERLEAVE)
   ) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (start),
      .base_i (addr_i[BEAT_W-1:0]),
      .step_i (cont && !adv_n),
      .beat_o (beat)
   );

endmodule

// File: rtl/pbsram_lane_mem.sv
module pbsram_lane_mem #(
   parameter int WIDTH = 9,
   parameter int DEPTH = 512,
   parameter int AW    = 9
) (
   input  logic             clk,
   input  logic             we_i,
   input  logic             re_i,
   input  logic [AW-1:0]    addr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] rdata_o
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [WIDTH-1:0] rd_q;

   always_ff @(posedge clk) begin
      if (we_i) mem[addr_i] <= wdata_i;
      if (re_i) rd_q <= mem[addr_i];
   end

   assign rdata_o = rd_q;

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core #(
   parameter int      DEPTH      = 512,
   parameter int      LANES      = 4,
   parameter int      LANE_W     = 9,
   parameter bit      INTERLEAVE = 1'b0,
   localparam int     AW         = $clog2(DEPTH),
   localparam int     DW         = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    addr_i,
   input  logic             proc_stb_n,
   input  logic             ctl_stb_n,
   input  logic             adv_n,
   input  logic             sel0_n,
   input  logic             sel1,
   input  logic             sel2_n,
   input  logic             wr_all_n,
   input  logic             wr_lane_en_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             drive_n,
   input  logic             sleep_i,
   input  logic [DW-1:0]    wdata_i,
   output logic [DW-1:0]    rdata_o,
   output logic             rdata_vld_o
);

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pbsram_core: DEPTH must be a power of two of at least 8");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("pbsram_core: LANES and LANE_W must be positive");
      end
   endgenerate

   logic [1:0]       sleep_q;
   logic             asleep;
   logic             acc_valid;
   logic             acc_wr;
   logic [AW-1:0]    acc_addr;
   logic [LANES-1:0] acc_mask;
   logic             rd_go;
   logic [DW-1:0]    mem_rd;
   logic [DW-1:0]    out_q;
   logic             rd_pend_q;
   logic             ovld_q;
   logic             wr_last_q;

   // two-edge sleep entry and exit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sleep_q <= '0;
      else        sleep_q <= {sleep_q[0], sleep_i};
   end
   assign asleep = sleep_q[1];

   pbsram_ctrl #(
      .AW         (AW),
      .LANES      (LANES),
      .INTERLEAVE (INTERLEAVE)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .asleep_i     (asleep),
      .addr_i       (addr_i),
      .proc_stb_n   (proc_stb_n),
      .ctl_stb_n    (ctl_stb_n),
      .adv_n        (adv_n),
      .sel0_n       (sel0_n),
      .sel1         (sel1),
      .sel2_n       (sel2_n),
      .wr_all_n     (wr_all_n),
      .wr_lane_en_n (wr_lane_en_n),
      .lane_sel_n   (lane_sel_n),
      .acc_valid_o  (acc_valid),
      .acc_wr_o     (acc_wr),
      .acc_addr_o   (acc_addr),
      .acc_mask_o   (acc_mask)
   );

   assign rd_go = acc_valid && !acc_wr;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         pbsram_lane_mem #(
            .WIDTH (LANE_W),
            .DEPTH (DEPTH),
            .AW    (AW)
         ) u_mem (
            .clk     (clk),
            .we_i    (acc_wr && acc_mask[l]),
            .re_i    (rd_go),
            .addr_i  (acc_addr),
            .wdata_i (wdata_i[l*LANE_W +: LANE_W]),
            .rdata_o (mem_rd[l*LANE_W +: LANE_W])
         );
      end
   endgenerate

   // second pipeline stage: output register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         ovld_q    <= 1'b0;
         wr_last_q <= 1'b0;
         out_q     <= '0;
      end else if (asleep) begin
         rd_pend_q <= 1'b0;
         ovld_q    <= 1'b0;
         wr_last_q <= 1'b0;
      end else begin
         rd_pend_q <= rd_go;
         ovld_q    <= rd_pend_q;
         wr_last_q <= acc_wr;
         out_q     <= mem_rd;
      end
   end

   assign rdata_vld_o = ovld_q && !wr_last_q && !drive_n && !asleep;
   assign rdata_o     = rdata_vld_o ? out_q : '0;

endmodule

// File: rtl/pbsram_core_chk.sv
module pbsram_core_chk #(
   parameter int AW         = 9,
   parameter bit INTERLEAVE = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          proc_stb_n,
   input logic          ctl_stb_n,
   input logic          adv_n,
   input logic          sel0_n,
   input logic          sel1,
   input logic          sel2_n,
   input logic          sleep_i,
   input logic          asleep,
   input logic          acc_valid,
   input logic          acc_wr,
   input logic [AW-1:0] acc_addr,
   input logic          rdata_vld_o
);

   logic chip_on;
   logic any_stb;
   assign chip_on = !sel0_n && sel1 && !sel2_n;
   assign any_stb = (!proc_stb_n && !sel0_n) || !ctl_stb_n;

   // R3
   rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_vld_o |-> $past(acc_valid && !acc_wr, 2));

   // R5 R7
   pfirst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && !proc_stb_n && chip_on) |-> !acc_wr);

   // R8
   desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep && any_stb && !chip_on) |-> ##2 !rdata_vld_o);

   // R10
   susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_valid) && acc_valid && proc_stb_n && ctl_stb_n && adv_n)
      |-> acc_addr == $past(acc_addr));

   // R9
   adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(acc_valid) && acc_valid && proc_stb_n && ctl_stb_n && !adv_n)
      |-> (INTERLEAVE != 1'b0) || (acc_addr[1:0] == 2'($past(acc_addr[1:0]) + 2'd1)));

   // R14
   sleep_ent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asleep |-> $past(sleep_i, 2));

   // R14
   sleep_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(asleep) && asleep) |-> !acc_valid);

endmodule

bind pbsram_core pbsram_core_chk #(
   .AW         (AW),
   .INTERLEAVE (INTERLEAVE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .proc_stb_n  (proc_stb_n),
   .ctl_stb_n   (ctl_stb_n),
   .adv_n       (adv_n),
   .sel0_n      (sel0_n),
   .sel1        (sel1),
   .sel2_n      (sel2_n),
   .sleep_i     (sleep_i),
   .asleep      (asleep),
   .acc_valid   (acc_valid),
   .acc_wr      (acc_wr),
   .acc_addr    (acc_addr),
   .rdata_vld_o (rdata_vld_o)
);

// File: tb/pbsram_core_tb.sv
module pbsram_core_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [5:0]  addr;
   logic        proc_stb_n, ctl_stb_n, adv_n;
   logic        sel0_n, sel1, sel2_n;
   logic        wr_all_n, wr_lane_en_n;
   logic [3:0]  lane_sel_n;
   logic        drive_n, sleep_i;
   logic [35:0] wdata;
   logic [35:0] rdata, rdata_il;
   logic        vld, vld_il;

   logic [35:0] ref_m [64];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   pbsram_core #(.DEPTH(64), .INTERLEAVE(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr_i(addr),
      .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
      .drive_n(drive_n), .sleep_i(sleep_i), .wdata_i(wdata),
      .rdata_o(rdata), .rdata_vld_o(vld));

   pbsram_core #(.DEPTH(16), .INTERLEAVE(1'b1)) u_dut_il (
      .clk(clk), .rst_n(rst_n), .addr_i(addr[3:0]),
      .proc_stb_n(proc_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
      .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
      .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n), .lane_sel_n(lane_sel_n),
      .drive_n(drive_n), .sleep_i(sleep_i), .wdata_i(wdata),
      .rdata_o(rdata_il), .rdata_vld_o(vld_il));

   task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      proc_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
      sel0_n = 1'b0; sel1 = 1'b1; sel2_n = 1'b0;
      wr_all_n = 1'b1; wr_lane_en_n = 1'b1; lane_sel_n = 4'hF;
      drive_n = 1'b0;
   endtask

   function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic wa_n, input logic wl_n, input logic [3:0] s_n);
      logic [3:0]  m;
      logic [35:0] r;
      m = !wa_n ? 4'hF : (!wl_n ? ~s_n : 4'h0);
      r = old;
      for (int l = 0; l < 4; l++) if (m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
      return r;
   endfunction

   task automatic c_wr(input logic [5:0] a, input logic [35:0] d,
                       input logic wa_n, input logic wl_n, input logic [3:0] s_n);
      ctl_stb_n = 1'b0; addr = a; wdata = d;
      wr_all_n = wa_n; wr_lane_en_n = wl_n; lane_sel_n = s_n;
      tick();
      idle();
      ref_m[a] = merge(ref_m[a], d, wa_n, wl_n, s_n);
   endtask

   task automatic rd_chk(input logic [5:0] a, input string req);
      ctl_stb_n = 1'b0; addr = a;
      tick();
      idle();
      tick();
      chk({req, " valid"}, {35'd0, vld}, 36'd1);
      chk({req, " data"}, rdata, ref_m[a]);
   endtask

   task automatic test_reset();
      chk("R1 valid after reset", {35'd0, vld}, 36'd0);
      chk("R1 data after reset", rdata, 36'd0);
   endtask

   task automatic test_latency();
      c_wr(6'd5, 36'h9_8765_4321, 1'b0, 1'b1, 4'hF);
      ctl_stb_n = 1'b0; addr = 6'd5;
      tick();
      chk("R3 not valid one edge after read", {35'd0, vld}, 36'd0);
      idle();
      tick();
      chk("R2 written word read back", rdata, ref_m[5]);
      chk("R3 valid two edges after read", {35'd0, vld}, 36'd1);
      ctl_stb_n = 1'b0; addr = 6'd6;
      tick();
      addr = 6'd7;
      tick();
      chk("R3 back-to-back first", rdata, ref_m[6]);
      idle();
      tick();
      chk("R3 back-to-back second", rdata, ref_m[7]);
   endtask

   task automatic test_lanes();
      c_wr(6'd8, 36'h0_0000_0000, 1'b0, 1'b1, 4'hF);
      c_wr(6'd8, 36'hF_FFFF_FFFF, 1'b1, 1'b0, 4'b1010);
      chk("R4 lanes 0 and 2 only", ref_m[8], 36'h0_07FC_01FF);
      rd_chk(6'd8, "R4 lane select");
      c_wr(6'd8, 36'h1_2345_6789, 1'b0, 1'b0, 4'hF);
      rd_chk(6'd8, "R4 whole word overrides selects");
      c_wr(6'd8, 36'h0_0000_0000, 1'b1, 1'b0, 4'hF);
      rd_chk(6'd8, "R4 no lane chosen is read");
   endtask

   task automatic test_pwrite();
      proc_stb_n = 1'b0; addr = 6'd10; wr_all_n = 1'b0; wdata = 36'hB_ADBA_DBAD;
      tick();
      proc_stb_n = 1'b1; wr_all_n = 1'b1; adv_n = 1'b1;
      tick();
      idle();
      rd_chk(6'd10, "R5 first-edge write ignored");
      proc_stb_n = 1'b0; addr = 6'd10;
      tick();
      proc_stb_n = 1'b1; wr_all_n = 1'b0; wdata = 36'h5_A5A5_0F0F;
      tick();
      idle();
      ref_m[10] = 36'h5_A5A5_0F0F;
      rd_chk(6'd10, "R5 second-edge write stored");
   endtask

   task automatic test_both();
      proc_stb_n = 1'b0; ctl_stb_n = 1'b0; addr = 6'd11;
      wr_all_n = 1'b0; wdata = 36'hB_ADBA_DBAD;
      tick();
      idle();
      tick();
      rd_chk(6'd11, "R7 processor strobe wins");
   endtask

   task automatic test_mask();
      ctl_stb_n = 1'b0; addr = 6'd12;
      tick();
      idle();
      tick();
      proc_stb_n = 1'b0; sel0_n = 1'b1; addr = 6'd40; adv_n = 1'b0;
      tick();
      idle();
      tick();
      chk("R6 masked strobe continues valid", {35'd0, vld}, 36'd1);
      chk("R6 masked strobe continues data", rdata, ref_m[13]);
   endtask

   task automatic test_desel();
      ctl_stb_n = 1'b0; addr = 6'd14;
      tick();
      sel1 = 1'b0;
      tick();
      chk("R8 prior read completes", rdata, ref_m[14]);
      idle();
      tick();
      chk("R8 invalid after deselect", {35'd0, vld}, 36'd0);
      tick();
      chk("R8 burst closed", {35'd0, vld}, 36'd0);
      ctl_stb_n = 1'b0; addr = 6'd15;
      tick();
      sel2_n = 1'b1;
      tick();
      idle();
      tick();
      chk("R8 third select deselects", {35'd0, vld}, 36'd0);
   endtask

   task automatic test_burst();
      ctl_stb_n = 1'b0; addr = 6'd22;
      tick();
      idle();
      adv_n = 1'b0;
      tick(); chk("R9 beat 0", rdata, ref_m[22]);
      tick(); chk("R9 beat 1", rdata, ref_m[23]);
      tick(); chk("R9 beat 2 wraps", rdata, ref_m[20]);
      tick(); chk("R9 beat 3", rdata, ref_m[21]);
      adv_n = 1'b1;
      tick(); chk("R9 counter back at base", rdata, ref_m[22]);
   endtask

   task automatic test_susp();
      ctl_stb_n = 1'b0; addr = 6'd21;
      tick();
      idle();
      tick(); chk("R10 first", rdata, ref_m[21]);
      tick(); chk("R10 held", rdata, ref_m[21]);
      adv_n = 1'b0;
      tick(); chk("R10 held again", rdata, ref_m[21]);
      adv_n = 1'b1;
      tick(); chk("R10 resumes", rdata, ref_m[22]);
   endtask

   task automatic test_il();
      logic [35:0] d [4];
      for (int i = 0; i < 4; i++) begin
         d[i] = 36'h3_0000_0000 + 36'(i * 36'h1_1111);
         c_wr(6'(4 + i), d[i], 1'b0, 1'b1, 4'hF);
      end
      ctl_stb_n = 1'b0; addr = 6'd5;
      tick();
      idle();
      adv_n = 1'b0;
      tick(); chk("R11 lin beat 0", rdata, d[1]); chk("R11 il beat 0", rdata_il, d[1]);
      tick(); chk("R11 lin beat 1", rdata, d[2]); chk("R11 il beat 1", rdata_il, d[0]);
      tick(); chk("R11 lin beat 2", rdata, d[3]); chk("R11 il beat 2", rdata_il, d[3]);
      tick(); chk("R11 lin beat 3", rdata, d[0]); chk("R11 il beat 3", rdata_il, d[2]);
      idle();
   endtask

   task automatic test_oe();
      ctl_stb_n = 1'b0; addr = 6'd24;
      tick();
      idle();
      tick();
      chk("R12 valid with drive", {35'd0, vld}, 36'd1);
      drive_n = 1'b1;
      #1;
      chk("R12 drive off valid", {35'd0, vld}, 36'd0);
      chk("R12 drive off data", rdata, 36'd0);
      drive_n = 1'b0;
      #1;
      chk("R12 drive back", rdata, ref_m[24]);
   endtask

   task automatic test_wrblank();
      proc_stb_n = 1'b0; addr = 6'd30;
      tick();
      proc_stb_n = 1'b1; wr_all_n = 1'b0; wdata = 36'hC_0FFE_E123;
      tick();
      chk("R13 blank on write cycle", {35'd0, vld}, 36'd0);
      idle();
      tick();
      chk("R13 blank after write", {35'd0, vld}, 36'd0);
      tick();
      chk("R13 written data", rdata, 36'hC_0FFE_E123);
      ref_m[30] = 36'hC_0FFE_E123;
   endtask

   task automatic test_sleep();
      ctl_stb_n = 1'b0; addr = 6'd40;
      tick();
      idle();
      sleep_i = 1'b1;
      tick();
      chk("R14 awake one edge after request", {35'd0, vld}, 36'd1);
      tick();
      chk("R14 asleep after two edges", {35'd0, vld}, 36'd0);
      ctl_stb_n = 1'b0; addr = 6'd40; wr_all_n = 1'b0; wdata = 36'hB_ADBA_DBAD;
      tick();
      idle();
      tick();
      chk("R14 no output asleep", {35'd0, vld}, 36'd0);
      sleep_i = 1'b0;
      tick();
      tick();
      tick();
      tick();
      chk("R14 open burst dropped", {35'd0, vld}, 36'd0);
      rd_chk(6'd40, "R14 contents kept");
   endtask

   initial begin
      rst_n = 1'b0; sleep_i = 1'b0; addr = '0; wdata = '0;
      idle();
      for (int i = 0; i < 64; i++) ref_m[i] = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      test_reset();
      for (int a = 0; a < 64; a++) c_wr(6'(a), {4{6'(a), 3'd5}}, 1'b0, 1'b1, 4'hF);
      test_latency();
      test_lanes();
      test_pwrite();
      test_both();
      test_mask();
      test_desel();
      test_burst();
      test_susp();
      test_il();
      test_oe();
      test_wrblank();
      test_sleep();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

endmodule